// File: doc/BRIEF.md
# Macro Result Router with Method Emitter

This block is the write-back end of a small macro engine. Each cycle the execute stage may offer one instruction result with a 3-bit routing mode and a destination register index. The router decides what goes into the register file: either the result itself or the next word taken from an incoming parameter stream. It also decides whether the result reloads the method address, and whether an (address, data) pair is sent out on the method port. The register file, the method address with its step value, and the parameter stream handshake all live here. The operand stage reads registers through two combinational read ports.

A macro begins with a one-cycle start pulse. The pulse clears the registers and the method state and places the first parameter word in register 1, so later fetches take the second and following words. The method address word keeps a 12-bit address in bits 11:0 and a 6-bit step in bits 17:12. Every emit sends the address in use and then advances it by the step, modulo 4096. At the end of a macro, an end pulse reports whether a parameter word is still waiting.

Top module: `macro_result_router`

## Requirements
- R1: After reset, every register reads zero, mth_valid_o and leftover_o are low, and the method address and step are zero.
- R2: Register 0 always reads zero. Writes to it are discarded.
- R3: A cycle with start_i high loads first_prm_i into register 1, clears every other register, clears the method address and step, and accepts no instruction (op_ready_o low).
- R4: Mode codes are 0 fetch, 1 move, 2 move+set, 3 fetch+send, 4 move+send, 5 fetch+set, 6 move+set+send-param, 7 move+set+send-step. Modes 0, 3 and 5 write the fetched parameter to the destination. All other modes write the result. The write is visible on the read ports in the cycle after acceptance.
- R5: A mode that fetches (0, 3, 5, 6) holds op_ready_o low until prm_valid_i is high. prm_ready_o is high only while a fetching instruction is offered. A parameter word is consumed only in the cycle its instruction is accepted.
- R6: Modes 2, 5, 6 and 7 load result bits 11:0 as the method address and result bits 17:12 as the step.
- R7: Modes 3 and 4 emit the result, mode 6 emits the fetched parameter, and mode 7 emits result bits 17:12 zero-extended. mth_valid_o is high for one cycle, in the cycle after acceptance, with mth_addr_o and mth_data_o.
- R8: An emit uses the current method address. In modes 6 and 7 that is the address just loaded. After each emit the address advances by the step, wrapping modulo 4096.
- R9: end_i high while prm_valid_i is high raises leftover_o in the next cycle. Otherwise leftover_o is low.
- R10: Modes 0, 1, 2 and 5 emit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Macro start pulse |
| first_prm_i | input | 32 | First parameter word, loaded into register 1 at start |
| op_valid_i | input | 1 | Instruction result offered |
| op_ready_o | output | 1 | Instruction accepted this cycle |
| op_mode_i | input | 3 | Routing mode |
| op_dst_i | input | 3 | Destination register |
| op_result_i | input | 32 | Instruction result |
| rd_a_idx_i | input | 3 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 3 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| prm_valid_i | input | 1 | Parameter word available |
| prm_ready_o | output | 1 | Parameter word taken |
| prm_data_i | input | 32 | Parameter word |
| end_i | input | 1 | End-of-macro check pulse |
| leftover_o | output | 1 | Unconsumed parameter seen at end |
| mth_valid_o | output | 1 | Method pair valid |
| mth_addr_o | output | 12 | Method address |
| mth_data_o | output | 32 | Method data |

## Verification
A wrong method address or step stays hidden until the next emit. At that point it shows on mth_addr_o one cycle after the emitting instruction is accepted. The stimulus therefore follows every reload with an emit, and it includes a step that carries the address past 4095. A wrong register write shows on the read ports in the cycle after acceptance, and each vector reads that register back. A handshake fault shows in the same cycle as op_ready_o or prm_ready_o: a lost stall, or a parameter taken by a mode that does not fetch.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  typedef enum logic [2:0] {
    M_FETCH          = 3'd0,
    M_MOVE           = 3'd1,
    M_MOVE_SET       = 3'd2,
    M_FETCH_SEND     = 3'd3,
    M_MOVE_SEND      = 3'd4,
    M_FETCH_SET      = 3'd5,
    M_MOVE_SET_PSEND = 3'd6,
    M_MOVE_SET_SSEND = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    SD_RESULT = 2'd0,
    SD_PARAM  = 2'd1,
    SD_STEP   = 2'd2
  } send_sel_e;

  typedef struct packed {
    logic      wr_param;
    logic      fetch;
    logic      set_m;
    logic      send;
    send_sel_e sel;
  } ctrl_t;

endpackage

// File: rtl/mrr_decode.sv
module mrr_decode
  import mrr_pkg::*;
(
  input  logic [2:0] mode_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o = '{wr_param: 1'b0, fetch: 1'b0, set_m: 1'b0, send: 1'b0, sel: SD_RESULT};
    unique case (mode_e'(mode_i))
      M_FETCH: begin
        ctrl_o.wr_param = 1'b1;
        ctrl_o.fetch    = 1'b1;
      end
      M_MOVE: ;
      M_MOVE_SET: ctrl_o.set_m = 1'b1;
      M_FETCH_SEND: begin
        ctrl_o.wr_param = 1'b1;
        ctrl_o.fetch    = 1'b1;
        ctrl_o.send     = 1'b1;
      end
      M_MOVE_SEND: ctrl_o.send = 1'b1;
      M_FETCH_SET: begin
        ctrl_o.wr_param = 1'b1;
        ctrl_o.fetch    = 1'b1;
        ctrl_o.set_m    = 1'b1;
      end
      M_MOVE_SET_PSEND: begin
        ctrl_o.fetch = 1'b1;
        ctrl_o.set_m = 1'b1;
        ctrl_o.send  = 1'b1;
        ctrl_o.sel   = SD_PARAM;
      end
      M_MOVE_SET_SSEND: begin
        ctrl_o.set_m = 1'b1;
        ctrl_o.send  = 1'b1;
        ctrl_o.sel   = SD_STEP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mrr_regfile.sv
module mrr_regfile #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 32,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [DW-1:0] init_r1_i,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [RW-1:0] ra_a_i,
  output logic [DW-1:0] rd_a_o,
  input  logic [RW-1:0] ra_b_i,
  output logic [DW-1:0] rd_b_o
);

  logic [DW-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          regs_q[i] <= '0;
        end else if (clear_i) begin
          regs_q[i] <= (i == 1) ? init_r1_i : '0;
        end else if (we_i && (waddr_i == RW'(i))) begin
          regs_q[i] <= wdata_i;
        end
      end
    end
  end

  assign rd_a_o = regs_q[ra_a_i];
  assign rd_b_o = regs_q[ra_b_i];

endmodule

// File: rtl/mrr_method.sv
module mrr_method #(
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 12,
  parameter int unsigned IW   = 6,
  parameter int unsigned ILSB = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          fire_i,
  input  logic          set_i,
  input  logic          send_i,
  input  logic [DW-1:0] result_i,
  input  logic [DW-1:0] sdata_i,
  output logic          emit_valid_o,
  output logic [AW-1:0] emit_addr_o,
  output logic [DW-1:0] emit_data_o
);

  logic [AW-1:0] addr_q, eff_addr;
  logic [IW-1:0] step_q, eff_step;

  // a reload takes effect before the emit in the same instruction
  assign eff_addr = set_i ? result_i[AW-1:0]   : addr_q;
  assign eff_step = set_i ? result_i[ILSB+:IW] : step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q       <= '0;
      step_q       <= '0;
      emit_valid_o <= 1'b0;
      emit_addr_o  <= '0;
      emit_data_o  <= '0;
    end else if (clear_i) begin
      addr_q       <= '0;
      step_q       <= '0;
      emit_valid_o <= 1'b0;
    end else begin
      emit_valid_o <= fire_i && send_i;
      if (fire_i && (set_i || send_i)) begin
        addr_q <= send_i ? eff_addr + AW'(eff_step) : eff_addr;
        step_q <= eff_step;
      end
      if (fire_i && send_i) begin
        emit_addr_o <= eff_addr;
        emit_data_o <= sdata_i;
      end
    end
  end

endmodule

// File: rtl/macro_result_router.sv
module macro_result_router
  import mrr_pkg::*;
#(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 12,
  parameter int unsigned IW   = 6,
  parameter int unsigned ILSB = 12,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] first_prm_i,
  input  logic          op_valid_i,
  output logic          op_ready_o,
  input  logic [2:0]    op_mode_i,
  input  logic [RW-1:0] op_dst_i,
  input  logic [DW-1:0] op_result_i,
  input  logic [RW-1:0] rd_a_idx_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [RW-1:0] rd_b_idx_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          prm_valid_i,
  output logic          prm_ready_o,
  input  logic [DW-1:0] prm_data_i,
  input  logic          end_i,
  output logic          leftover_o,
  output logic          mth_valid_o,
  output logic [AW-1:0] mth_addr_o,
  output logic [DW-1:0] mth_data_o
);

  ctrl_t         ctrl;
  logic          fire;
  logic [DW-1:0] wdata, sdata;

  mrr_decode u_dec (
    .mode_i (op_mode_i),
    .ctrl_o (ctrl)
  );

  assign op_ready_o  = !start_i && (!ctrl.fetch || prm_valid_i);
  assign prm_ready_o = !start_i && op_valid_i && ctrl.fetch;
  assign fire        = op_valid_i && op_ready_o;

  assign wdata = ctrl.wr_param ? prm_data_i : op_result_i;

  always_comb begin
    unique case (ctrl.sel)
      SD_PARAM: sdata = prm_data_i;
      SD_STEP:  sdata = DW'(op_result_i[ILSB+:IW]);
      default:  sdata = op_result_i;
    endcase
  end

  mrr_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_i),
    .init_r1_i (first_prm_i),
    .we_i      (fire),
    .waddr_i   (op_dst_i),
    .wdata_i   (wdata),
    .ra_a_i    (rd_a_idx_i),
    .rd_a_o    (rd_a_data_o),
    .ra_b_i    (rd_b_idx_i),
    .rd_b_o    (rd_b_data_o)
  );

  mrr_method #(.DW(DW), .AW(AW), .IW(IW), .ILSB(ILSB)) u_mth (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (start_i),
    .fire_i       (fire),
    .set_i        (ctrl.set_m),
    .send_i       (ctrl.send),
    .result_i     (op_result_i),
    .sdata_i      (sdata),
    .emit_valid_o (mth_valid_o),
    .emit_addr_o  (mth_addr_o),
    .emit_data_o  (mth_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) leftover_o <= 1'b0;
    else         leftover_o <= end_i && prm_valid_i;
  end

endmodule

// File: rtl/mrr_checker.sv
module mrr_checker #(
  parameter int unsigned RW = 3,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          op_valid_i,
  input logic          op_ready_o,
  input logic [2:0]    op_mode_i,
  input logic [RW-1:0] rd_a_idx_i,
  input logic [DW-1:0] rd_a_data_o,
  input logic          prm_valid_i,
  input logic          prm_ready_o,
  input logic          end_i,
  input logic          leftover_o,
  input logic          mth_valid_o
);

  logic is_fetch, is_send, acc;
  assign is_fetch = (op_mode_i == 3'd0) || (op_mode_i == 3'd3) ||
                    (op_mode_i == 3'd5) || (op_mode_i == 3'd6);
  assign is_send  = (op_mode_i == 3'd3) || (op_mode_i == 3'd4) ||
                    (op_mode_i == 3'd6) || (op_mode_i == 3'd7);
  assign acc      = op_valid_i && op_ready_o;

  p_zero_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_idx_i == '0 |-> rd_a_data_o == '0);

  p_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && is_fetch && !prm_valid_i |-> !op_ready_o);

  p_prm_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prm_ready_o |-> op_valid_i && is_fetch);

  p_start_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !op_ready_o);

  p_emit_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mth_valid_o |-> $past(acc && is_send));

  p_no_emit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !is_send |=> !mth_valid_o);

  p_leftover_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leftover_o |-> $past(end_i && prm_valid_i));

endmodule

bind macro_result_router mrr_checker #(.RW(RW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .op_valid_i  (op_valid_i),
  .op_ready_o  (op_ready_o),
  .op_mode_i   (op_mode_i),
  .rd_a_idx_i  (rd_a_idx_i),
  .rd_a_data_o (rd_a_data_o),
  .prm_valid_i (prm_valid_i),
  .prm_ready_o (prm_ready_o),
  .end_i       (end_i),
  .leftover_o  (leftover_o),
  .mth_valid_o (mth_valid_o)
);

// File: tb/macro_result_router_bench.sv
module macro_result_router_bench;

  typedef struct packed {
    logic        fet;
    logic [2:0]  mode;
    logic [2:0]  dst;
    logic [31:0] res;
    logic [31:0] prm;
    logic [31:0] exp_reg;
    logic        emit;
    logic [11:0] eaddr;
    logic [31:0] edata;
  } vec_t;

  // fet mode dst result param exp_reg emit addr data
  localparam vec_t VT [12] = '{
    '{1'b0, 3'd1, 3'd2, 32'hAAAA0001, 32'h0,    32'hAAAA0001, 1'b0, 12'h000, 32'h0},
    '{1'b0, 3'd4, 3'd3, 32'h55,       32'h0,    32'h55,       1'b1, 12'h000, 32'h55},
    '{1'b0, 3'd2, 3'd4, 32'h3100,     32'h0,    32'h3100,     1'b0, 12'h000, 32'h0},
    '{1'b1, 3'd3, 3'd5, 32'hDEAD,     32'h77,   32'h77,       1'b1, 12'h100, 32'hDEAD},
    '{1'b0, 3'd4, 3'd6, 32'h1,        32'h0,    32'h1,        1'b1, 12'h103, 32'h1},
    '{1'b1, 3'd0, 3'd7, 32'hFFFF,     32'h1234, 32'h1234,     1'b0, 12'h000, 32'h0},
    '{1'b1, 3'd5, 3'd2, 32'h20FFF,    32'h99,   32'h99,       1'b0, 12'h000, 32'h0},
    '{1'b0, 3'd4, 3'd3, 32'h7,        32'h0,    32'h7,        1'b1, 12'hFFF, 32'h7},
    '{1'b1, 3'd6, 3'd4, 32'h15040,    32'hCAFE, 32'h15040,    1'b1, 12'h040, 32'hCAFE},
    '{1'b0, 3'd7, 3'd5, 32'h3F00A,    32'h0,    32'h3F00A,    1'b1, 12'h00A, 32'h3F},
    '{1'b0, 3'd4, 3'd0, 32'h123,      32'h0,    32'h0,        1'b1, 12'h049, 32'h123},
    '{1'b1, 3'd0, 3'd0, 32'h0,        32'h5,    32'h0,        1'b0, 12'h000, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] first_prm = '0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_mode = '0;
  logic [2:0]  op_dst = '0;
  logic [31:0] op_result = '0;
  logic [2:0]  rd_a_idx = '0;
  logic [31:0] rd_a_data;
  logic [2:0]  rd_b_idx = '0;
  logic [31:0] rd_b_data;
  logic        prm_valid = 1'b0;
  logic        prm_ready;
  logic [31:0] prm_data = '0;
  logic        end_chk = 1'b0;
  logic        leftover;
  logic        mth_valid;
  logic [11:0] mth_addr;
  logic [31:0] mth_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  macro_result_router u_macro_result_router (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .first_prm_i(first_prm),
    .op_valid_i(op_valid), .op_ready_o(op_ready), .op_mode_i(op_mode),
    .op_dst_i(op_dst), .op_result_i(op_result),
    .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
    .prm_valid_i(prm_valid), .prm_ready_o(prm_ready), .prm_data_i(prm_data),
    .end_i(end_chk), .leftover_o(leftover),
    .mth_valid_o(mth_valid), .mth_addr_o(mth_addr), .mth_data_o(mth_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    rd_a_idx = idx;
    #1 val = rd_a_data;
  endtask

  task automatic do_start(input logic [31:0] p);
    @(negedge clk);
    start = 1'b1; first_prm = p; op_valid = 1'b1; op_mode = 3'd1;
    #1 chk("R3 op_ready low during start", 32'(op_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; op_valid = 1'b0;
  endtask

  // drive one instruction at negedge, accepted at the next posedge
  task automatic issue(input logic [2:0] m, input logic [2:0] d, input logic [31:0] r,
                       input logic pv, input logic [31:0] pd);
    @(negedge clk);
    op_valid = 1'b1; op_mode = m; op_dst = d; op_result = r;
    prm_valid = pv; prm_data = pd;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; prm_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 mth_valid after reset", 32'(mth_valid), 32'd0);
    chk("R1 leftover after reset", 32'(leftover), 32'd0);
    rst_n = 1'b1;

    do_start(32'h11);
    rd(3'd1, v);
    chk("R3 r1 holds first param", v, 32'h11);

    // vector walk: R4 R6 R7 R8 R10 R2
    for (int k = 0; k < 12; k++) begin
      issue(VT[k].mode, VT[k].dst, VT[k].res, VT[k].fet, VT[k].prm);
      rd(VT[k].dst, v);
      chk("R4 dst write", v, VT[k].exp_reg);
      chk("R7 R10 emit flag", 32'(mth_valid), 32'(VT[k].emit));
      if (VT[k].emit) begin
        chk("R8 emit address", 32'(mth_addr), 32'(VT[k].eaddr));
        chk("R7 emit data", mth_data, VT[k].edata);
      end
    end
    rd(3'd0, v);
    chk("R2 r0 after writes", v, 32'h0);
    rd_b_idx = 3'd5;
    #1 chk("R4 read port b", rd_b_data, 32'h3F00A);

    // R3 restart clears registers and method state
    do_start(32'h22);
    rd(3'd1, v);
    chk("R3 r1 reloaded", v, 32'h22);
    rd(3'd2, v);
    chk("R3 r2 cleared", v, 32'h0);
    issue(3'd4, 3'd6, 32'h9, 1'b0, 32'h0);
    chk("R3 method address cleared", 32'(mth_addr), 32'h0);
    chk("R7 emit after restart", 32'(mth_valid), 32'd1);

    // R5 stall on fetch with no parameter
    @(negedge clk);
    op_valid = 1'b1; op_mode = 3'd3; op_dst = 3'd2; op_result = 32'h44;
    prm_valid = 1'b0; prm_data = 32'hBEEF;
    #1;
    chk("R5 stall op_ready", 32'(op_ready), 32'd0);
    chk("R5 prm_ready while fetch offered", 32'(prm_ready), 32'd1);
    @(negedge clk);
    rd(3'd2, v);
    chk("R5 no write while stalled", v, 32'h0);
    chk("R5 no emit while stalled", 32'(mth_valid), 32'd0);
    prm_valid = 1'b1;
    #1 chk("R5 ready once param valid", 32'(op_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; prm_valid = 1'b0;
    rd(3'd2, v);
    chk("R5 param written after stall", v, 32'hBEEF);
    chk("R8 emit after stall", 32'(mth_addr), 32'h0);
    chk("R7 data after stall", mth_data, 32'h44);

    // R5 non-fetch mode does not take parameters
    op_valid = 1'b1; op_mode = 3'd1; op_dst = 3'd3; op_result = 32'h66;
    prm_valid = 1'b1; prm_data = 32'h1;
    #1;
    chk("R5 prm_ready low for move", 32'(prm_ready), 32'd0);
    chk("R5 move ready without fetch", 32'(op_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    rd(3'd3, v);
    chk("R4 move writes result", v, 32'h66);

    // R9 leftover flag
    end_chk = 1'b1;
    @(negedge clk);
    chk("R9 leftover with pending param", 32'(leftover), 32'd1);
    prm_valid = 1'b0;
    @(negedge clk);
    end_chk = 1'b0;
    chk("R9 no leftover when empty", 32'(leftover), 32'd0);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule